// File: doc/BRIEF.md
# VGA Planar Address and Plane-Enable Mapper

This block sits between the host memory port and a four-plane VGA frame buffer. It takes each host memory access and checks whether it falls in the selected display window. It then turns the host byte address into a frame-buffer DWORD index and four plane byte enables. One DWORD index covers one byte position across all four planes.

Three addressing schemes are supported. In the plain scheme, the plane enables are the map-mask register. In the interleaved scheme, address bit 0 picks the even or the odd plane pair, and the page bit takes the place of index bit 0. In the chained-by-four scheme, address bits [1:0] pick a single plane and index bits [1:0] are cleared. Both chained schemes AND their steering with the map mask.

Word and DWORD host accesses are split into single-byte beats at ascending addresses, one beat per accepted cycle. The host request is held until the last beat has gone out. The mapping is combinational on the current beat, so a beat appears in the same cycle as the request that produces it.

Top module: `vga_plane_mapper`

## Requirements
- R1: Window select `win_sel_i` chooses the decoded region from host address bits [31:15]. 0 selects 000A0000h–000AFFFFh. 1 selects 000B0000h–000B7FFFh. 2 selects 000B8000h–000BFFFFh. 3 selects no region.
- R2: A beat whose byte address is outside the selected region has `out_hit_o` low and `out_plane_en_o` equal to 0000.
- R3: In the plain scheme (`chain4_i`=0, `odd_even_i`=0), a hit beat has `out_fb_addr_o` equal to byte address bits [15:0] and `out_plane_en_o` equal to `map_mask_i`. Plane p is bit p of the enables.
- R4: In the interleaved scheme (`odd_even_i`=1, `chain4_i`=0), address bit 0 = 0 selects planes 0 and 2 (0101b) and bit 0 = 1 selects planes 1 and 3 (1010b).
- R5: In the interleaved scheme, bit 0 of `out_fb_addr_o` equals `page_bit_i`. The other bits equal address bits [15:1].
- R6: In the chained-by-four scheme (`chain4_i`=1), at most one plane enable is set, namely plane = address bits [1:0], and `out_fb_addr_o` bits [1:0] are 00.
- R7: In both chained schemes, the address-derived enables are ANDed with `map_mask_i`. No enable is ever set whose map-mask bit is clear.
- R8: When `chain4_i` and `odd_even_i` are both set, the chained-by-four scheme applies.
- R9: `req_size_i` sets the lane count: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes. Lane k has byte address `req_addr_i`+k. Enabled lanes are emitted in ascending order, one per accepted beat.
- R10: A lane whose `req_be_i` bit is clear is skipped and takes no beat. A request with no enabled lane is accepted at once and produces no beat.
- R11: `req_ready_o` stays low until the beat of the last enabled lane is accepted. While `out_ready_i` is low, the current beat stays presented unchanged.
- R12: After reset, and whenever no request is valid, `out_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| win_sel_i | input | 2 | Display window select |
| chain4_i | input | 1 | Chained-by-four scheme enable |
| odd_even_i | input | 1 | Interleaved (odd/even) scheme enable |
| page_bit_i | input | 1 | Page bit used as index bit 0 in the interleaved scheme |
| map_mask_i | input | 4 | Plane write mask |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Host request complete |
| req_addr_i | input | 32 | Host byte address |
| req_size_i | input | 2 | Access size code |
| req_be_i | input | 4 | Host lane enables |
| out_valid_o | output | 1 | Byte beat valid |
| out_ready_i | input | 1 | Byte beat accepted |
| out_fb_addr_o | output | 16 | Frame-buffer DWORD index |
| out_plane_en_o | output | 4 | Plane byte enables |
| out_hit_o | output | 1 | Beat falls in the selected window |

## Verification
Some checks run on every cycle. They cover the single-plane and cleared-low-bits rule of the chained-by-four scheme, the page-bit substitution, that the enables are never wider than the map mask, zero enables on a miss, and that the host is never released while a beat is still stalled. They also check that each accepted non-final beat retires exactly one lane. Other properties need the bench's scenarios: the exact window edges, the even/odd pair patterns, the scheme priority, ascending lane order across a region boundary, skipped lanes, empty requests and behaviour under back-pressure. Those depend on specific expected values that a per-cycle property cannot state.

// File: rtl/vga_map_pkg.sv
package vga_map_pkg;
  typedef enum logic [1:0] {
    WIN_SEG_A   = 2'd0,
    WIN_SEG_BLO = 2'd1,
    WIN_SEG_BHI = 2'd2,
    WIN_NONE    = 2'd3
  } win_sel_e;

  localparam int unsigned HOST_AW   = 32;
  localparam int unsigned FB_AW     = 16;
  localparam int unsigned PLANES    = 4;
  localparam int unsigned MAX_LANES = 4;
endpackage

// File: rtl/vga_byte_splitter.sv
module vga_byte_splitter #(
  parameter int unsigned AW    = 32,
  parameter int unsigned LANES = 4,
  localparam int unsigned IW   = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [AW-1:0] req_addr_i,
  input  logic [1:0]    req_size_i,
  input  logic [LANES-1:0] req_be_i,
  output logic          beat_valid_o,
  input  logic          beat_ready_i,
  output logic [AW-1:0] beat_addr_o
);
  logic [LANES-1:0] done_q, done_d, lane_mask, remain, cur_oh;
  logic [IW-1:0]    cur_idx;
  logic             multi;

  always_comb begin
    for (int k = 0; k < int'(LANES); k++)
      lane_mask[k] = req_be_i[k] && (k < (1 << int'(req_size_i)));
  end

  assign remain = lane_mask & ~done_q;
  assign multi  = |(remain & (remain - LANES'(1)));

  always_comb begin
    cur_idx = '0;
    for (int k = int'(LANES) - 1; k >= 0; k--)
      if (remain[k]) cur_idx = IW'(k);
  end

  assign cur_oh       = LANES'(1) << cur_idx;
  assign beat_valid_o = req_valid_i && (|remain);
  assign req_ready_o  = req_valid_i && ((remain == '0) || (!multi && beat_ready_i));
  assign beat_addr_o  = req_addr_i + AW'(cur_idx);

  always_comb begin
    done_d = done_q;
    if (req_valid_i && req_ready_o)        done_d = '0;
    else if (beat_valid_o && beat_ready_i) done_d = done_q | cur_oh;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_q <= '0;
    else         done_q <= done_d;
  end

  assert_no_beat_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o |-> req_valid_i);

  assert_release_last_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && beat_valid_o) |-> beat_ready_i);

  assert_one_lane_per_beat_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_o && beat_ready_i && !req_ready_o) |=>
      ($countones(done_q) == $countones($past(done_q)) + 1));
endmodule

// File: rtl/vga_window_decode.sv
module vga_window_decode
  import vga_map_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [1:0]    win_sel_i,
  input  logic [AW-1:0] addr_i,
  output logic          hit_o
);
  localparam int unsigned SW = AW - 16;
  localparam logic [SW-1:0] SEG_A = SW'(16'h000A);
  localparam logic [SW-1:0] SEG_B = SW'(16'h000B);

  logic [SW-1:0] seg;
  logic          upper_half;

  assign seg        = addr_i[AW-1:16];
  assign upper_half = addr_i[15];

  always_comb begin
    unique case (win_sel_e'(win_sel_i))
      WIN_SEG_A:   hit_o = (seg == SEG_A);
      WIN_SEG_BLO: hit_o = (seg == SEG_B) && !upper_half;
      WIN_SEG_BHI: hit_o = (seg == SEG_B) && upper_half;
      default:     hit_o = 1'b0;
    endcase
  end

  assert_hit_in_low_mb_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && hit_o) |-> (addr_i[AW-1:20] == '0 && win_sel_i != 2'd3));
endmodule

// File: rtl/vga_plane_steer.sv
module vga_plane_steer #(
  parameter int unsigned FAW    = 16,
  parameter int unsigned PLANES = 4,
  localparam int unsigned PW    = $clog2(PLANES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              hit_i,
  input  logic [FAW-1:0]    addr_i,
  input  logic              chain4_i,
  input  logic              odd_even_i,
  input  logic              page_bit_i,
  input  logic [PLANES-1:0] map_mask_i,
  output logic [FAW-1:0]    fb_addr_o,
  output logic [PLANES-1:0] plane_en_o
);
  logic [PLANES-1:0] c4_sel, oe_sel, raw_en;

  for (genvar p = 0; p < int'(PLANES); p++) begin : g_plane
    localparam logic [PW-1:0] PIDX = PW'(p);
    assign c4_sel[p] = (addr_i[PW-1:0] == PIDX);
    assign oe_sel[p] = (addr_i[0] == PIDX[0]);
  end

  always_comb begin
    if (chain4_i) begin
      raw_en    = c4_sel;
      fb_addr_o = {addr_i[FAW-1:PW], {PW{1'b0}}};
    end else if (odd_even_i) begin
      raw_en    = oe_sel;
      fb_addr_o = {addr_i[FAW-1:1], page_bit_i};
    end else begin
      raw_en    = '1;
      fb_addr_o = addr_i;
    end
    plane_en_o = hit_i ? (raw_en & map_mask_i) : '0;
  end

  assert_c4_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && chain4_i) |-> ($onehot0(plane_en_o) && fb_addr_o[PW-1:0] == '0));

  assert_c4_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && chain4_i && odd_even_i) |-> (fb_addr_o[PW-1:0] == '0));

  assert_page_bit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && odd_even_i && !chain4_i) |-> (fb_addr_o[0] == page_bit_i));

  assert_mask_subset_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> ((plane_en_o & ~map_mask_i) == '0));

  assert_miss_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !hit_i) |-> (plane_en_o == '0));
endmodule

// File: rtl/vga_plane_mapper.sv
module vga_plane_mapper
  import vga_map_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [1:0]           win_sel_i,
  input  logic                 chain4_i,
  input  logic                 odd_even_i,
  input  logic                 page_bit_i,
  input  logic [PLANES-1:0]    map_mask_i,
  input  logic                 req_valid_i,
  output logic                 req_ready_o,
  input  logic [HOST_AW-1:0]   req_addr_i,
  input  logic [1:0]           req_size_i,
  input  logic [MAX_LANES-1:0] req_be_i,
  output logic                 out_valid_o,
  input  logic                 out_ready_i,
  output logic [FB_AW-1:0]     out_fb_addr_o,
  output logic [PLANES-1:0]    out_plane_en_o,
  output logic                 out_hit_o
);
  logic [HOST_AW-1:0] beat_addr;
  logic               beat_valid, hit;

  vga_byte_splitter #(.AW(HOST_AW), .LANES(MAX_LANES)) u_split (
    .clk_i, .rst_ni,
    .req_valid_i, .req_ready_o, .req_addr_i, .req_size_i, .req_be_i,
    .beat_valid_o(beat_valid), .beat_ready_i(out_ready_i), .beat_addr_o(beat_addr)
  );

  vga_window_decode #(.AW(HOST_AW)) u_win (
    .clk_i, .rst_ni, .valid_i(beat_valid), .win_sel_i, .addr_i(beat_addr), .hit_o(hit)
  );

  vga_plane_steer #(.FAW(FB_AW), .PLANES(PLANES)) u_steer (
    .clk_i, .rst_ni, .valid_i(beat_valid), .hit_i(hit), .addr_i(beat_addr[FB_AW-1:0]),
    .chain4_i, .odd_even_i, .page_bit_i, .map_mask_i,
    .fb_addr_o(out_fb_addr_o), .plane_en_o(out_plane_en_o)
  );

  assign out_valid_o = beat_valid;
  assign out_hit_o   = hit;

  assert_stall_holds_host_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |-> !req_ready_o);
endmodule

// File: tb/vga_plane_mapper_bench.sv
module vga_plane_mapper_bench;
  logic        clk = 1'b0, rst_ni = 1'b0;
  logic [1:0]  win_sel = 2'd0;
  logic        chain4 = 1'b0, odd_even = 1'b0, page_bit = 1'b0;
  logic [3:0]  map_mask = 4'hF;
  logic        req_valid = 1'b0, req_ready;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [3:0]  req_be = 4'h1;
  logic        out_valid, out_ready = 1'b1, out_hit;
  logic [15:0] out_fb;
  logic [3:0]  out_en;
  int total = 0, bad = 0, cyc = 0;

  always #10 clk = ~clk;

  vga_plane_mapper u_vga_plane_mapper (
    .clk_i(clk), .rst_ni, .win_sel_i(win_sel), .chain4_i(chain4), .odd_even_i(odd_even),
    .page_bit_i(page_bit), .map_mask_i(map_mask), .req_valid_i(req_valid),
    .req_ready_o(req_ready), .req_addr_i(req_addr), .req_size_i(req_size), .req_be_i(req_be),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_fb_addr_o(out_fb),
    .out_plane_en_o(out_en), .out_hit_o(out_hit)
  );

  typedef struct packed {
    logic [31:0] addr; logic [1:0] win; logic c4; logic oe; logic pg;
    logic [3:0] mm; logic hit; logic [15:0] fb; logic [3:0] en;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{32'h000A1234, 2'd0, 1'b0, 1'b0, 1'b0, 4'hF, 1'b1, 16'h1234, 4'hF}, // R1 R3
    '{32'h000B1234, 2'd0, 1'b0, 1'b0, 1'b0, 4'hF, 1'b0, 16'h0000, 4'h0}, // R1 R2
    '{32'h000B1234, 2'd1, 1'b0, 1'b0, 1'b0, 4'h5, 1'b1, 16'h1234, 4'h5}, // R1 R3
    '{32'h000B9234, 2'd1, 1'b0, 1'b0, 1'b0, 4'hF, 1'b0, 16'h0000, 4'h0}, // R1
    '{32'h000B9234, 2'd2, 1'b0, 1'b0, 1'b0, 4'hF, 1'b1, 16'h9234, 4'hF}, // R1
    '{32'h000A5671, 2'd0, 1'b0, 1'b1, 1'b0, 4'hF, 1'b1, 16'h5670, 4'hA}, // R4 R5
    '{32'h000A5670, 2'd0, 1'b0, 1'b1, 1'b1, 4'hF, 1'b1, 16'h5671, 4'h5}, // R4 R5
    '{32'h000A5671, 2'd0, 1'b0, 1'b1, 1'b1, 4'h3, 1'b1, 16'h5671, 4'h2}, // R7
    '{32'h000A0003, 2'd0, 1'b1, 1'b0, 1'b0, 4'hF, 1'b1, 16'h0000, 4'h8}, // R6
    '{32'h000A0006, 2'd0, 1'b1, 1'b0, 1'b0, 4'hF, 1'b1, 16'h0004, 4'h4}, // R6
    '{32'h000A0006, 2'd0, 1'b1, 1'b0, 1'b0, 4'hB, 1'b1, 16'h0004, 4'h0}, // R7
    '{32'h000A0005, 2'd0, 1'b1, 1'b1, 1'b1, 4'hF, 1'b1, 16'h0004, 4'h2}, // R8
    '{32'h000A1234, 2'd3, 1'b0, 1'b0, 1'b0, 4'hF, 1'b0, 16'h0000, 4'h0}, // R1
    '{32'h001A0000, 2'd0, 1'b0, 1'b0, 1'b0, 4'hF, 1'b0, 16'h0000, 4'h0}  // R1 R2
  };

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // inputs set at negedge; sample 2 ns later, then let one edge pass
  task automatic beat(input logic [15:0] fb, input logic [3:0] en, input bit hit,
                      input bit last, input string tag);
    #2;
    chk(out_valid === 1'b1, {tag, " valid"}, 32'(out_valid), 1);
    chk(out_hit === hit, {tag, " hit"}, 32'(out_hit), 32'(hit));
    chk(out_en === en, {tag, " en"}, 32'(out_en), 32'(en));
    if (hit) chk(out_fb === fb, {tag, " fb"}, 32'(out_fb), 32'(fb));
    chk(req_ready === last, {tag, " ready"}, 32'(req_ready), 32'(last));
    @(posedge clk); @(negedge clk);
  endtask

  task automatic mode(input logic [1:0] w, input bit c4, input bit oe, input bit pg, input logic [3:0] mm);
    win_sel = w; chain4 = c4; odd_even = oe; page_bit = pg; map_mask = mm;
  endtask

  task automatic issue(input logic [31:0] a, input logic [1:0] sz, input logic [3:0] be);
    req_addr = a; req_size = sz; req_be = be; req_valid = 1'b1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 5000);
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    chk(out_valid === 1'b0, "R12 reset valid", 32'(out_valid), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    #2;
    chk(out_valid === 1'b0, "R12 idle valid", 32'(out_valid), 0);
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      mode(VECS[i].win, VECS[i].c4, VECS[i].oe, VECS[i].pg, VECS[i].mm);
      issue(VECS[i].addr, 2'd0, 4'h1);
      beat(VECS[i].fb, VECS[i].en, VECS[i].hit, 1'b1, $sformatf("R1-table vec%0d", i));
      req_valid = 1'b0;
    end

    // R9: word split, ascending
    mode(2'd0, 0, 0, 0, 4'hF);
    issue(32'h000A0000, 2'd1, 4'hF);
    beat(16'h0000, 4'hF, 1, 0, "R9 word b0");
    beat(16'h0001, 4'hF, 1, 1, "R9 word b1");
    req_valid = 1'b0;

    // R9 R6: dword in chained-by-four, size code 3
    mode(2'd0, 1, 0, 0, 4'hF);
    issue(32'h000A0002, 2'd3, 4'hF);
    beat(16'h0000, 4'h4, 1, 0, "R9 c4 b0");
    beat(16'h0000, 4'h8, 1, 0, "R9 c4 b1");
    beat(16'h0004, 4'h1, 1, 0, "R9 c4 b2");
    beat(16'h0004, 4'h2, 1, 1, "R9 c4 b3");
    req_valid = 1'b0;

    // R10: skipped lanes
    mode(2'd0, 0, 0, 0, 4'hF);
    issue(32'h000A0010, 2'd2, 4'b1010);
    beat(16'h0011, 4'hF, 1, 0, "R10 skip b1");
    beat(16'h0013, 4'hF, 1, 1, "R10 skip b3");
    req_valid = 1'b0;

    // R10: empty request
    issue(32'h000A0020, 2'd2, 4'b0000);
    #2;
    chk(out_valid === 1'b0, "R10 empty valid", 32'(out_valid), 0);
    chk(req_ready === 1'b1, "R10 empty ready", 32'(req_ready), 1);
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;

    // R11: stall holds beat and host
    issue(32'h000A0100, 2'd1, 4'h3);
    out_ready = 1'b0;
    for (int s = 0; s < 3; s++) begin
      #2;
      chk(out_valid === 1'b1 && out_fb === 16'h0100, "R11 stall beat", 32'(out_fb), 32'h0100);
      chk(req_ready === 1'b0, "R11 stall ready", 32'(req_ready), 0);
      @(posedge clk); @(negedge clk);
    end
    out_ready = 1'b1;
    beat(16'h0100, 4'hF, 1, 0, "R11 b0");
    out_ready = 1'b0;
    #2;
    chk(out_fb === 16'h0101 && req_ready === 1'b0, "R11 stall last", 32'(req_ready), 0);
    @(posedge clk); @(negedge clk);
    out_ready = 1'b1;
    beat(16'h0101, 4'hF, 1, 1, "R11 b1");
    req_valid = 1'b0;

    // R1 R9: word crossing the window edge
    issue(32'h000AFFFF, 2'd1, 4'h3);
    beat(16'hFFFF, 4'hF, 1, 0, "R9 edge b0");
    beat(16'h0000, 4'h0, 0, 1, "R2 edge b1");
    req_valid = 1'b0;
    #2;
    chk(out_valid === 1'b0, "R12 drop valid", 32'(out_valid), 0);

    summary();
  end
endmodule